// File: doc/BRIEF.md
# Linked Page-Table Address Translator

This block maps write addresses from a linear trace-buffer input space onto 4 KB physical data pages that can sit anywhere in memory. The map is held in memory as a chain of 4 KB table pages. Each table page covers a 1 MB window of the input space and carries links to its neighbours. The block holds one current table page and its window number. A request that lands in the held window costs one entry read. A request that lands in another window first walks the chain, reading one link entry per hop, until it reaches the target table.

Software writes two addresses into configuration inputs. The first is the 1 MB-aligned input base. The second is the address of the table page that maps the window starting at that base. Requests enter on a valid/ready handshake, and only one is handled at a time. Each request returns one response pulse, carrying either a translated address or a fault. Every fault also sets a flag that stays set until reset. Table entries are fetched through a simple read port: the block sends a one-cycle request pulse and receives one data beat later.

Top module: `lpt_xlate`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, mem_req and fault_flag are 0. The held table is the page at cfg_tbl_base, and its window index is 0.
- R2: req_ready is 1 only while no request is in progress. Each accepted request produces exactly one rsp_valid pulse, one cycle long. The pulse may share its cycle with the acceptance of the next request.
- R3: The offset is req_addr minus the base; bits 19:0 of cfg_in_base are ignored. The window index is offset bits 47:20 and the entry slot is offset bits 19:12. For a request in the held window, the only read goes to byte address table_page + slot*8.
- R4: An entry is 64 bits. Bit 0 is the valid flag and bits 47:12 are a 4 KB page address. A valid data entry gives rsp_fault=0 and rsp_addr = {entry[47:12], req_addr[11:0]}.
- R5: A data entry with bit 0 clear gives rsp_fault=1 with rsp_addr=0.
- R6: When the target window index is above the held one, the block reads slot 511 (byte offset 0xFF8) of the held table. It then moves to the linked page and repeats, one hop per read, until the windows match.
- R7: When the target window index is below the held one, the block walks the same way through slot 510 (byte offset 0xFF0).
- R8: After a walk, the reached table and window stay held. A later request in the same window needs no link read.
- R9: A req_addr below the base gives a fault response without any memory read.
- R10: A link entry with bit 0 clear ends the walk with a fault response. The held table stays at the last table reached.
- R11: fault_flag rises with the first fault response and stays 1 until reset, including across later successful translations.
- R12: mem_req is a one-cycle pulse. No new pulse is sent before mem_rvalid has returned the previous read.
- R13: With the default parameters, entry bits 11:1 have no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_in_base | input | 48 | Input-space base; bits 19:0 ignored |
| cfg_tbl_base | input | 48 | Byte address of the first table page (4 KB aligned) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 48 | Input address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response carries a fault |
| rsp_addr | output | 48 | Translated address, 0 on fault |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 48 | Byte address of the 64-bit entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Table entry read from memory |
| fault_flag | output | 1 | Sticky fault status |

## Verification
The response strobe of one request and the acceptance of the next can fall in the same cycle, because req_ready is already high while rsp_valid is shown. The bench provokes this by presenting a second request on the very cycle the first response appears. It then checks that both answers are correct and that the first strobe lasts only one cycle. It also checks that the second request's read is the only one it issues. A fault response and the sticky flag update share a cycle as well, so the flag is checked together with the faulting response.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SEEK,
      ST_WAIT
   } lpt_state_e;

   typedef enum logic [1:0] {
      RD_DATA,
      RD_NEXT,
      RD_PREV
   } lpt_rd_e;
endpackage

// File: rtl/lpt_locate.sv
module lpt_locate #(
   parameter int AW         = 48,
   parameter int PAGE_SHIFT = 12,
   parameter int WIN_SHIFT  = 20
) (
   input  logic [AW-1:0]                   addr,
   input  logic [AW-1:0]                   base,
   output logic                            below,
   output logic [AW-WIN_SHIFT-1:0]         win_idx,
   output logic [WIN_SHIFT-PAGE_SHIFT-1:0] slot
);
   logic [AW-1:0] base_al;
   logic [AW-1:0] offset;

   assign base_al = {base[AW-1:WIN_SHIFT], {WIN_SHIFT{1'b0}}};
   assign below   = addr < base_al;
   assign offset  = addr - base_al;
   assign win_idx = offset[AW-1:WIN_SHIFT];
   assign slot    = offset[WIN_SHIFT-1:PAGE_SHIFT];
endmodule

// File: rtl/lpt_entry_dec.sv
module lpt_entry_dec #(
   parameter int AW         = 48,
   parameter int EW         = 64,
   parameter int PAGE_SHIFT = 12,
   parameter bit CHECK_SBZ  = 1'b0
) (
   input  logic [EW-1:0]         entry,
   output logic                  valid,
   output logic [AW-PAGE_SHIFT-1:0] page
);
   assign page = entry[AW-1:PAGE_SHIFT];

   generate
      if (CHECK_SBZ) begin : g_strict
         assign valid = entry[0] && (entry[PAGE_SHIFT-1:1] == '0);
      end else begin : g_loose
         assign valid = entry[0];
      end
   endgenerate
endmodule

// File: rtl/lpt_xlate.sv
module lpt_xlate
   import lpt_pkg::*;
#(
   parameter int AW         = 48,
   parameter int EW         = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int WIN_SHIFT  = 20,
   parameter bit CHECK_SBZ  = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] cfg_in_base,
   input  logic [AW-1:0] cfg_tbl_base,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   output logic          rsp_valid,
   output logic          rsp_fault,
   output logic [AW-1:0] rsp_addr,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [EW-1:0] mem_rdata,
   output logic          fault_flag
);
   localparam int PG_W      = AW - PAGE_SHIFT;
   localparam int TI_W      = AW - WIN_SHIFT;
   localparam int SL_W      = WIN_SHIFT - PAGE_SHIFT;
   localparam int EB_SH     = $clog2(EW / 8);
   localparam int ESL_W     = PAGE_SHIFT - EB_SH;
   localparam int SLOT_NEXT = (1 << ESL_W) - 1;
   localparam int SLOT_PREV = SLOT_NEXT - 1;

   generate
      if (AW > EW || AW <= WIN_SHIFT) begin : g_bad_aw
         $error("lpt_xlate: AW must exceed WIN_SHIFT and not exceed EW");
      end
      if (SL_W + 1 > ESL_W) begin : g_bad_win
         $error("lpt_xlate: data pointers must fit in half a table page");
      end
      if (EW != 64) begin : g_bad_ew
         $error("lpt_xlate: entry width must be 64");
      end
   endgenerate

   lpt_state_e        state_q;
   lpt_rd_e           kind_q;
   logic [AW-1:0]     addr_q;
   logic [TI_W-1:0]   tgt_q;
   logic [SL_W-1:0]   slot_q;
   logic [PG_W-1:0]   cur_pg_q;
   logic [TI_W-1:0]   cur_ti_q;
   logic              mem_req_q;
   logic [AW-1:0]     mem_addr_q;
   logic              rsp_valid_q;
   logic              rsp_fault_q;
   logic [AW-1:0]     rsp_addr_q;
   logic              fault_q;

   logic              in_below;
   logic [TI_W-1:0]   in_win;
   logic [SL_W-1:0]   in_slot;
   logic              ent_ok;
   logic [PG_W-1:0]   ent_pg;
   logic [ESL_W-1:0]  seek_slot;
   lpt_rd_e           seek_kind;

   lpt_locate #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .WIN_SHIFT(WIN_SHIFT)) u_locate (
      .addr    (req_addr),
      .base    (cfg_in_base),
      .below   (in_below),
      .win_idx (in_win),
      .slot    (in_slot)
   );

   lpt_entry_dec #(.AW(AW), .EW(EW), .PAGE_SHIFT(PAGE_SHIFT), .CHECK_SBZ(CHECK_SBZ)) u_dec (
      .entry (mem_rdata),
      .valid (ent_ok),
      .page  (ent_pg)
   );

   always_comb begin
      if (tgt_q == cur_ti_q) begin
         seek_slot = ESL_W'(slot_q);
         seek_kind = RD_DATA;
      end else if (tgt_q > cur_ti_q) begin
         seek_slot = ESL_W'(SLOT_NEXT);
         seek_kind = RD_NEXT;
      end else begin
         seek_slot = ESL_W'(SLOT_PREV);
         seek_kind = RD_PREV;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         kind_q      <= RD_DATA;
         addr_q      <= '0;
         tgt_q       <= '0;
         slot_q      <= '0;
         cur_pg_q    <= cfg_tbl_base[AW-1:PAGE_SHIFT];
         cur_ti_q    <= '0;
         mem_req_q   <= 1'b0;
         mem_addr_q  <= '0;
         rsp_valid_q <= 1'b0;
         rsp_fault_q <= 1'b0;
         rsp_addr_q  <= '0;
         fault_q     <= 1'b0;
      end else begin
         rsp_valid_q <= 1'b0;
         mem_req_q   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q <= req_addr;
                  tgt_q  <= in_win;
                  slot_q <= in_slot;
                  if (in_below) begin
                     rsp_valid_q <= 1'b1;
                     rsp_fault_q <= 1'b1;
                     rsp_addr_q  <= '0;
                     fault_q     <= 1'b1;
                  end else begin
                     state_q <= ST_SEEK;
                  end
               end
            end
            ST_SEEK: begin
               mem_req_q  <= 1'b1;
               mem_addr_q <= {cur_pg_q, seek_slot, {EB_SH{1'b0}}};
               kind_q     <= seek_kind;
               state_q    <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rvalid) begin
                  if (!ent_ok) begin
                     rsp_valid_q <= 1'b1;
                     rsp_fault_q <= 1'b1;
                     rsp_addr_q  <= '0;
                     fault_q     <= 1'b1;
                     state_q     <= ST_IDLE;
                  end else if (kind_q == RD_DATA) begin
                     rsp_valid_q <= 1'b1;
                     rsp_fault_q <= 1'b0;
                     rsp_addr_q  <= {ent_pg, addr_q[PAGE_SHIFT-1:0]};
                     state_q     <= ST_IDLE;
                  end else begin
                     cur_pg_q <= ent_pg;
                     cur_ti_q <= (kind_q == RD_NEXT) ? cur_ti_q + 1'b1 : cur_ti_q - 1'b1;
                     state_q  <= ST_SEEK;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign rsp_valid  = rsp_valid_q;
   assign rsp_fault  = rsp_fault_q;
   assign rsp_addr   = rsp_addr_q;
   assign mem_req    = mem_req_q;
   assign mem_addr   = mem_addr_q;
   assign fault_flag = fault_q;

   AST_MEM_PULSE: assert property (@(posedge clk) disable iff (rst)
      mem_req |=> !mem_req) else $error("mem_req held"); // R12
   AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> (!req_ready || rsp_valid)) else $error("second request taken"); // R2
   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
      fault_flag |=> fault_flag) else $error("fault flag cleared"); // R11
   AST_FAULT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_fault) |-> fault_flag) else $error("fault not flagged"); // R11
   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_fault) |-> (rsp_addr == '0)) else $error("fault with address"); // R5
endmodule

// File: tb/lpt_xlate_bench.sv
module lpt_xlate_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [47:0] BASE = 48'h0000_4000_0000;
   localparam logic [47:0] T0   = 48'h0000_0001_0000;
   localparam logic [47:0] T1   = 48'h0000_0004_0000;
   localparam logic [47:0] T2   = 48'h0000_0002_3000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [47:0] req_addr = '0;
   logic        req_ready, rsp_valid, rsp_fault, mem_req, fault_flag;
   logic [47:0] rsp_addr, mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int lat = 1;
   int rd_n = 0;
   int viol = 0;
   logic [47:0] rd_log [64];
   logic        pend = 1'b0;
   int          pcnt = 0;
   logic [47:0] paddr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpt_xlate u_lpt_xlate (
      .clk(clk), .rst(rst), .cfg_in_base(BASE), .cfg_tbl_base(T0),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .fault_flag(fault_flag)
   );

   function automatic logic [35:0] dpage(input int t, input int s);
      return 36'h90_0000 + 36'((t * 256 + s) ^ 'h5A);
   endfunction

   function automatic logic [63:0] model(input logic [47:0] a);
      logic [35:0] pg;
      int s;
      int t;
      pg = a[47:12];
      s  = int'(a[11:3]);
      t  = (pg == T0[47:12]) ? 0 : (pg == T1[47:12]) ? 1 : (pg == T2[47:12]) ? 2 : -1;
      if (t < 0) return 64'h0;
      if (s < 256) begin
         if (t == 2 && s >= 128) return 64'h0;
         // window 1 entries carry junk in bits 11:1
         return {16'h0, dpage(t, s), (t == 1) ? 12'h6A1 : 12'h001};
      end
      if (s == 510) return {16'h0, (t == 0) ? T2[47:12] : (t == 1) ? T0[47:12] : T1[47:12], 12'h001};
      if (s == 511) begin
         if (t == 0) return {16'h0, T1[47:12], 12'h001};
         if (t == 1) return {16'h0, T2[47:12], 12'h001};
      end
      return 64'h0;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         if (pend) viol <= viol + 1;
         rd_log[rd_n % 64] <= mem_addr;
         rd_n  <= rd_n + 1;
         pend  <= 1'b1;
         pcnt  <= lat - 1;
         paddr <= mem_addr;
      end else if (pend) begin
         if (pcnt == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= model(paddr);
            pend       <= 1'b0;
         end else begin
            pcnt <= pcnt - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_req(input logic [47:0] ad, output logic f, output logic [47:0] ra, output int first);
      int k;
      @(negedge clk);
      k = 0;
      while (!req_ready && k < 300) begin @(negedge clk); k++; end
      first = rd_n;
      req_valid = 1'b1;
      req_addr  = ad;
      @(negedge clk);
      req_valid = 1'b0;
      k = 0;
      while (!rsp_valid && k < 300) begin @(negedge clk); k++; end
      f  = rsp_fault;
      ra = rsp_addr;
      if (!rsp_valid) chk(1'b0, "R2 response missing", 0, 1);
   endtask

   task automatic t_reset;
      chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
      chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
      chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
      chk(fault_flag == 1'b0, "R1 fault_flag", fault_flag, 0);
   endtask

   task automatic t_held0;
      logic f; logic [47:0] ra; int st;
      lat = 1;
      do_req(BASE + 48'h5123, f, ra, st);
      chk(rd_n - st == 1, "R3 read count", rd_n - st, 1);
      chk(rd_log[st % 64] == T0 + 48'd40, "R1 R3 entry address", rd_log[st % 64], T0 + 48'd40);
      chk(f == 1'b0, "R4 no fault", f, 0);
      chk(ra == {dpage(0, 5), 12'h123}, "R4 translation", ra, {dpage(0, 5), 12'h123});
   endtask

   task automatic t_sbz;
      logic f; logic [47:0] ra; int st;
      lat = 2;
      do_req(BASE + 48'h10_40AA, f, ra, st);
      chk(rd_n - st == 2, "R6 hop count", rd_n - st, 2);
      chk(rd_log[st % 64] == T0 + 48'hFF8, "R6 next slot", rd_log[st % 64], T0 + 48'hFF8);
      chk(rd_log[(st + 1) % 64] == T1 + 48'd32, "R6 linked table", rd_log[(st + 1) % 64], T1 + 48'd32);
      chk(!f && ra == {dpage(1, 4), 12'h0AA}, "R13 junk bits ignored", ra, {dpage(1, 4), 12'h0AA});
   endtask

   task automatic t_fwd;
      logic f; logic [47:0] ra; int st;
      lat = 3;
      do_req(BASE + 48'h27_FABC, f, ra, st);
      chk(rd_n - st == 2, "R6 hop count", rd_n - st, 2);
      chk(rd_log[st % 64] == T1 + 48'hFF8, "R6 next slot", rd_log[st % 64], T1 + 48'hFF8);
      chk(rd_log[(st + 1) % 64] == T2 + 48'h3F8, "R6 entry", rd_log[(st + 1) % 64], T2 + 48'h3F8);
      chk(!f && ra == {dpage(2, 'h7F), 12'hABC}, "R6 translation", ra, {dpage(2, 'h7F), 12'hABC});
   endtask

   task automatic t_same;
      logic f; logic [47:0] ra; int st;
      do_req(BASE + 48'h21_0000, f, ra, st);
      chk(rd_n - st == 1, "R8 no link read", rd_n - st, 1);
      chk(rd_log[st % 64] == T2 + 48'h80, "R8 held table", rd_log[st % 64], T2 + 48'h80);
      chk(!f && ra == {dpage(2, 'h10), 12'h000}, "R8 translation", ra, {dpage(2, 'h10), 12'h000});
   endtask

   task automatic t_back;
      logic f; logic [47:0] ra; int st;
      lat = 1;
      do_req(BASE + 48'h0_9FFF, f, ra, st);
      chk(rd_n - st == 3, "R7 hop count", rd_n - st, 3);
      chk(rd_log[st % 64] == T2 + 48'hFF0, "R7 prev slot", rd_log[st % 64], T2 + 48'hFF0);
      chk(rd_log[(st + 1) % 64] == T1 + 48'hFF0, "R7 prev slot", rd_log[(st + 1) % 64], T1 + 48'hFF0);
      chk(rd_log[(st + 2) % 64] == T0 + 48'h48, "R7 entry", rd_log[(st + 2) % 64], T0 + 48'h48);
      chk(!f && ra == {dpage(0, 9), 12'hFFF}, "R7 translation", ra, {dpage(0, 9), 12'hFFF});
   endtask

   task automatic t_b2b;
      int k; int st;
      @(negedge clk);
      st = rd_n;
      req_valid = 1'b1; req_addr = BASE + 48'h2010;
      @(negedge clk);
      req_valid = 1'b0;
      k = 0;
      while (!rsp_valid && k < 300) begin @(negedge clk); k++; end
      chk(rsp_valid && !rsp_fault && rsp_addr == {dpage(0, 2), 12'h010}, "R2 first answer", rsp_addr, {dpage(0, 2), 12'h010});
      chk(req_ready == 1'b1, "R2 ready with response", req_ready, 1);
      req_valid = 1'b1; req_addr = BASE + 48'h3020;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b0, "R2 one-cycle strobe", rsp_valid, 0);
      chk(req_ready == 1'b0, "R2 second accepted", req_ready, 0);
      k = 0;
      while (!rsp_valid && k < 300) begin @(negedge clk); k++; end
      chk(rsp_valid && !rsp_fault && rsp_addr == {dpage(0, 3), 12'h020}, "R2 second answer", rsp_addr, {dpage(0, 3), 12'h020});
      chk(rd_n - st == 2 && rd_log[(st + 1) % 64] == T0 + 48'h18, "R2 second read", rd_log[(st + 1) % 64], T0 + 48'h18);
   endtask

   task automatic t_bad_data;
      logic f; logic [47:0] ra; int st;
      chk(fault_flag == 1'b0, "R11 flag clear before fault", fault_flag, 0);
      do_req(BASE + 48'h2C_8000, f, ra, st);
      chk(rd_n - st == 3, "R5 reads", rd_n - st, 3);
      chk(f == 1'b1 && ra == 48'h0, "R5 invalid entry fault", {f, ra}, {1'b1, 48'h0});
      chk(fault_flag == 1'b1, "R11 flag set", fault_flag, 1);
   endtask

   task automatic t_bad_link;
      logic f; logic [47:0] ra; int st;
      do_req(BASE + 48'h30_0000, f, ra, st);
      chk(rd_n - st == 1 && rd_log[st % 64] == T2 + 48'hFF8, "R10 link read", rd_log[st % 64], T2 + 48'hFF8);
      chk(f == 1'b1 && ra == 48'h0, "R10 link fault", {f, ra}, {1'b1, 48'h0});
      do_req(BASE + 48'h20_1000, f, ra, st);
      chk(rd_n - st == 1 && rd_log[st % 64] == T2 + 48'h8, "R10 table kept", rd_log[st % 64], T2 + 48'h8);
      chk(!f && ra == {dpage(2, 1), 12'h000}, "R10 translation after", ra, {dpage(2, 1), 12'h000});
   endtask

   task automatic t_below;
      logic f; logic [47:0] ra; int st;
      do_req(BASE - 48'h1000, f, ra, st);
      chk(rd_n - st == 0, "R9 no read", rd_n - st, 0);
      chk(f == 1'b1 && ra == 48'h0, "R9 fault", {f, ra}, {1'b1, 48'h0});
      do_req(BASE + 48'h20_2000, f, ra, st);
      chk(!f && fault_flag == 1'b1, "R11 sticky after success", fault_flag, 1);
      chk(viol == 0, "R12 read protocol", viol, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_held0();
      t_sbz();
      t_fwd();
      t_same();
      t_back();
      t_b2b();
      t_bad_data();
      t_bad_link();
      t_below();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(negedge clk) begin
      if (cyc > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule